// File: doc/BRIEF.md
# Pulse-Width Modulator with Queued Duty Samples

This block generates a pulse-width-modulated output from a prescaled up-counter. A period register sets how many counter ticks make up one period. A control register sets the prescaler that divides the clock into ticks. Duty values (samples) are written through a small register interface into a short queue. The output goes high at the start of every period and falls once the counter reaches the active compare value.

The active compare value changes only at a period boundary. At every boundary the block pops the oldest queued sample, if there is one, into the compare register. If the queue is empty, the current value stays. A sample written while the queue is empty waits in the queue for the next boundary. It never takes effect mid-period. So lowering the duty late in a period cannot leave the output high for the whole period.

Software programs the period and the prescaler first. It then fills the queue and sets the enable bit. It can read back the fill level, the active compare value and the live count at any time.

Top module: `pwm_modulator`

## Requirements
- R1: Registers decode at byte offsets control 0x00, status 0x04, sample 0x0C, period 0x10 and count 0x14. Control holds enable in bit 0, the prescaler field in bits 15:4, a stop-enable flag in bit 25 and a 2-bit watermark field in bits 27:26. All of these read back as written. After reset every register reads 0 and the output is low.
- R2: One period lasts (P+2) counter ticks, where P is the period register value. One tick lasts (F+1) clock cycles, where F is the prescaler field.
- R3: A period write larger than the parameter PERIOD_MAX is stored and read back as PERIOD_MAX.
- R4: The output is high for the first min(S, P+2) ticks of a period, where S is the active compare value. S = 0 keeps it low for the whole period, and S >= P+2 keeps it high for the whole period.
- R5: A sample write pushes its low DW bits into a queue of DEPTH entries. Status bits 3:0 report how many entries hold data.
- R6: At every period boundary, including the first period after enable is set, the oldest queued sample moves into the active compare register. If the queue is empty the previous compare value stays. The sample register reads the active compare value.
- R7: A sample written during a period, with the queue empty, does not change that period's pulse. It applies from the next period on.
- R8: A sample write while the queue is full is dropped and sets a sticky overflow flag in status bit 4. Writing 1 to status bit 4 clears the flag.
- R9: Clearing enable while the block runs drives the output low, returns the count to 0 and empties the queue.
- R10: The count register reads the current tick count within the period. It runs from 0 to P+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pwm_out | output | 1 | Modulated output |

## Verification
A register write takes effect at the clock edge that samples it, and reads return data in the same cycle. Setting enable starts the first period one edge later. Each later period starts exactly (P+2)(F+1) cycles after the one before. The bench starts its window counter on the cycle after that start edge. It counts high samples per window at falling edges and compares each window with the value expected for that sample queue, so late writes and empty-queue writes show up in the right window. Count and status reads wait for the edge that updates them: one edge for a queue change, and two edges after enable is cleared.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int PRESC_W = 12;

    localparam logic [4:0] OFS_CTRL  = 5'h00;
    localparam logic [4:0] OFS_STAT  = 5'h04;
    localparam logic [4:0] OFS_SMPL  = 5'h0C;
    localparam logic [4:0] OFS_PER   = 5'h10;
    localparam logic [4:0] OFS_CNT   = 5'h14;

    localparam int BIT_EN      = 0;
    localparam int PRESC_LSB   = 4;
    localparam int BIT_STOP    = 25;
    localparam int WMARK_LSB   = 26;
    localparam int BIT_OVF     = 4;

    typedef struct packed {
        logic [1:0]         wmark;
        logic               stop_en;
        logic [PRESC_W-1:0] presc;
        logic               en;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_CTRL, SEL_STAT, SEL_SMPL, SEL_PER, SEL_CNT, SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode(input logic [4:0] a);
        case (a)
            OFS_CTRL: return SEL_CTRL;
            OFS_STAT: return SEL_STAT;
            OFS_SMPL: return SEL_SMPL;
            OFS_PER:  return SEL_PER;
            OFS_CNT:  return SEL_CNT;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic logic [31:0] pack_ctrl(input ctrl_t c);
        logic [31:0] r;
        r = '0;
        r[BIT_EN] = c.en;
        r[PRESC_LSB +: PRESC_W] = c.presc;
        r[BIT_STOP] = c.stop_en;
        r[WMARK_LSB +: 2] = c.wmark;
        return r;
    endfunction

endpackage

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          flush,
    input  logic                          push,
    input  logic [W-1:0]                  din,
    input  logic                          pop,
    output logic [W-1:0]                  head,
    output logic [$clog2(DEPTH+1)-1:0]    level,
    output logic                          full,
    output logic                          empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH+1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [PW-1:0] div,
    output logic          tick
);
    logic [PW-1:0] pcnt;

    assign tick = run && (pcnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) pcnt <= '0;
        else                     pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/pwm_period_core.sv
module pwm_period_core #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          tick,
    input  logic [DW-1:0] period,
    input  logic [DW-1:0] head,
    input  logic          q_empty,
    output logic          run,
    output logic          pop,
    output logic [DW-1:0] cnt,
    output logic [DW-1:0] cmp
);
    logic [DW-1:0] last;
    logic          start, wrap;

    assign last  = period + 1'b1;
    assign start = en && !run;
    assign wrap  = run && tick && (cnt >= last);
    assign pop   = start || wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (!en) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= '0;
        end else if (tick) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                  cmp <= '0;
        else if (pop && !q_empty) cmp <= head;
    end
endmodule

// File: rtl/pwm_modulator.sv
module pwm_modulator #(
    parameter int DW         = 16,
    parameter int DEPTH      = 4,
    parameter int PERIOD_MAX = (1 << DW) - 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        pwm_out
);
    import pwm_pkg::*;

    localparam int LVL_W = $clog2(DEPTH+1);

    ctrl_t            ctrl_q;
    logic [DW-1:0]    per_q;
    logic             ovf_q;
    reg_sel_e         sel;
    logic             wr, push, flush, ovf_clr, ctrl_en;
    logic [DW-1:0]    head, cnt, cmp;
    logic [LVL_W-1:0] fifo_level;
    logic             full, empty, tick, run, pop;
    logic             unused_wbits;

    assign sel     = decode(bus_addr);
    assign wr      = bus_en && bus_we;
    assign push    = wr && (sel == SEL_SMPL);
    assign flush   = wr && (sel == SEL_CTRL) && !bus_wdata[BIT_EN] && ctrl_q.en;
    assign ovf_clr = wr && (sel == SEL_STAT) && bus_wdata[BIT_OVF];
    assign ctrl_en = ctrl_q.en;
    assign unused_wbits = ^{bus_wdata[31:28], bus_wdata[24:16], bus_wdata[3:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            per_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (wr && sel == SEL_CTRL) begin
                ctrl_q.en      <= bus_wdata[BIT_EN];
                ctrl_q.presc   <= bus_wdata[PRESC_LSB +: PRESC_W];
                ctrl_q.stop_en <= bus_wdata[BIT_STOP];
                ctrl_q.wmark   <= bus_wdata[WMARK_LSB +: 2];
            end
            if (wr && sel == SEL_PER)
                per_q <= (bus_wdata > 32'(PERIOD_MAX)) ? DW'(PERIOD_MAX) : bus_wdata[DW-1:0];
            if (push && full)  ovf_q <= 1'b1;
            else if (ovf_clr)  ovf_q <= 1'b0;
        end
    end

    pwm_sample_fifo #(.W(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .flush(flush), .push(push),
        .din(bus_wdata[DW-1:0]), .pop(pop), .head(head),
        .level(fifo_level), .full(full), .empty(empty)
    );

    pwm_prescaler #(.PW(PRESC_W)) u_presc (
        .clk(clk), .rst(rst), .run(run), .div(ctrl_q.presc), .tick(tick)
    );

    pwm_period_core #(.DW(DW)) u_core (
        .clk(clk), .rst(rst), .en(ctrl_q.en), .tick(tick), .period(per_q),
        .head(head), .q_empty(empty), .run(run), .pop(pop),
        .cnt(cnt), .cmp(cmp)
    );

    assign pwm_out = run && ctrl_q.en && (cnt < cmp);

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CTRL: bus_rdata = pack_ctrl(ctrl_q);
            SEL_STAT: begin
                bus_rdata[3:0]     = 4'(fifo_level);
                bus_rdata[BIT_OVF] = ovf_q;
            end
            SEL_SMPL: bus_rdata = 32'(cmp);
            SEL_PER:  bus_rdata = 32'(per_q);
            SEL_CNT:  bus_rdata = 32'(cnt);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pwm_modulator_chk.sv
module pwm_modulator_chk #(
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       en,
    input logic                       ovf,
    input logic                       ovf_clr,
    input logic                       out,
    input logic [DW-1:0]              cnt,
    input logic [DW-1:0]              cmp,
    input logic [$clog2(DEPTH+1)-1:0] level
);
    // R9: one edge after enable is low, count is 0 and output is low
    assert_stop_clears_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0) && !out);

    // R7: the compare register only moves at a period boundary
    assert_cmp_at_boundary_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(cmp) |-> (cnt == '0));

    // R5: the fill level never exceeds the depth
    assert_level_bound_R5: assert property (@(posedge clk) disable iff (rst)
        int'(level) <= DEPTH);

    // R8: overflow flag stays until cleared
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        ovf && !ovf_clr |=> ovf);

    // R4: a pulse only begins at the start of a period
    assert_rise_at_start_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(out) |-> (cnt == '0));
endmodule

bind pwm_modulator pwm_modulator_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .en(ctrl_en), .ovf(ovf_q), .ovf_clr(ovf_clr),
    .out(pwm_out), .cnt(cnt), .cmp(cmp), .level(fifo_level)
);

// File: tb/test_pwm_modulator.sv
module test_pwm_modulator;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int DEPTH = 4;
    localparam int PMAX = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int n_tests = 0;
    int n_fail = 0;

    // window monitor state
    bit    mon_on = 1'b0;
    int    mon_len = 0;
    int    n_win = 0;
    int    win = 0;
    int    phase = 0;
    int    hi = 0;
    int    exp_hi [16];
    string mon_req = "";

    pwm_modulator #(.DW(DW), .DEPTH(DEPTH), .PERIOD_MAX(PMAX)) i_pwm_modulator (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output int d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic start_windows(input int len, input int cnt_w, input string req, input int ctrl);
        mon_len = len; n_win = cnt_w; mon_req = req;
        win = 0; phase = 0; hi = 0;
        bus_write(5'h00, 32'(ctrl));
        @(posedge clk);
        #1;
        mon_on = 1'b1;
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            if (pwm_out) hi++;
            phase++;
            if (phase == mon_len) begin
                check($sformatf("%s window %0d", mon_req, win), hi, exp_hi[win]);
                win++; phase = 0; hi = 0;
                if (win == n_win) mon_on = 1'b0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        bus_read(5'h00, v); check("R1 ctrl reset", v, 0);
        bus_read(5'h04, v); check("R1 status reset", v, 0);
        bus_read(5'h14, v); check("R1 count reset", v, 0);
        bus_read(5'h0C, v); check("R1 sample reset", v, 0);
        check("R1 output reset", int'(pwm_out), 0);

        // R1: control field readback
        bus_write(5'h00, (32'd1 << 25) | (32'd2 << 26) | (32'h5A << 4));
        bus_read(5'h00, v);
        check("R1 ctrl fields", v, int'((32'd1 << 25) | (32'd2 << 26) | (32'h5A << 4)));
        bus_write(5'h00, 32'd0);

        // S1: P=10, divide by 1, period 12 cycles
        bus_write(5'h10, 32'd10);
        bus_write(5'h0C, 32'd5);
        bus_write(5'h0C, 32'd0);
        bus_write(5'h0C, 32'd12);
        bus_write(5'h0C, 32'd8);
        bus_read(5'h04, v); check("R5 level after four pushes", v, 4);
        exp_hi[0] = 5; exp_hi[1] = 0; exp_hi[2] = 12; exp_hi[3] = 8;
        exp_hi[4] = 8; exp_hi[5] = 3; exp_hi[6] = 3;
        start_windows(12, 7, "R4/R6/R7 width", 1);
        wait (win == 1 && phase == 3);
        bus_read(5'h0C, v); check("R6 sample reads active compare", v, 0);
        wait (win == 2 && phase == 5);
        bus_read(5'h14, v); check("R10 count mid period", v, 5);
        // R7: late smaller sample with empty queue
        wait (win == 4 && phase == 9);
        bus_write(5'h0C, 32'd3);
        wait (!mon_on);
        bus_write(5'h0C, 32'd9);
        bus_write(5'h0C, 32'd9);
        bus_read(5'h04, v); check("R5 level while running", v, 2);
        bus_write(5'h00, 32'd0);
        repeat (2) @(posedge clk);
        bus_read(5'h14, v); check("R9 count cleared", v, 0);
        bus_read(5'h04, v); check("R9 queue flushed", v, 0);
        check("R9 output low", int'(pwm_out), 0);

        // S2: prescaler field 2 (divide by 3), P=4
        bus_write(5'h00, 32'd2 << 4);
        bus_write(5'h10, 32'd4);
        bus_write(5'h0C, 32'd2);
        bus_write(5'h0C, 32'd6);
        bus_write(5'h0C, 32'd3);
        exp_hi[0] = 6; exp_hi[1] = 18; exp_hi[2] = 9;
        start_windows(18, 3, "R2 prescaled width", (2 << 4) | 1);
        wait (!mon_on);
        bus_write(5'h00, 32'd0);

        // S3: period clamp to PMAX
        bus_write(5'h10, 32'd200);
        bus_read(5'h10, v); check("R3 period clamped", v, PMAX);
        bus_write(5'h0C, 32'd41);
        bus_write(5'h0C, 32'd50);
        exp_hi[0] = 41; exp_hi[1] = 42;
        start_windows(PMAX + 2, 2, "R3 clamped period width", 1);
        wait (!mon_on);
        bus_write(5'h00, 32'd0);

        // S4: overflow, P=6
        bus_write(5'h10, 32'd6);
        for (int k = 1; k <= 5; k++) bus_write(5'h0C, 32'(k));
        bus_read(5'h04, v); check("R8 full level and overflow flag", v, 20);
        bus_write(5'h04, 32'h10);
        bus_read(5'h04, v); check("R8 overflow cleared", v, 4);
        exp_hi[0] = 1; exp_hi[1] = 2; exp_hi[2] = 3; exp_hi[3] = 4; exp_hi[4] = 4;
        start_windows(8, 5, "R8 dropped sample absent", 1);
        wait (!mon_on);
        bus_write(5'h00, 32'd0);
        repeat (2) @(posedge clk);
        check("R9 output low at end", int'(pwm_out), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule